// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a small serial memory that answers on a two-wire bus. The system clock oversamples both bus lines. Each line passes a two-flop synchronizer and a short agreement filter, and the filtered lines are then watched for start and stop conditions and for clock edges. Bytes arrive most significant bit first. The first byte of every transaction is a control byte, which names the device, the memory block and the transfer direction. The engine answers by pulling the data line low through an output enable, so the pad stays open-drain.

For a write, the engine takes a word address and then any number of data bytes into a page buffer. A stop commits the buffer into an internal byte array and starts a busy period. For a read, the engine streams bytes from a single address pointer that reads and writes share. This supports current-address, random and sequential reads. While the busy period runs, the engine acknowledges nothing, so a bus master can poll for the end of the write.

Top module: `twe_slave`

## Requirements
- R1: A control byte is acknowledged only if its bits 7..4 equal 1010 and no write is busy; bit 0 selects read (1) or write (0). A control byte that does not match is not acknowledged, and the bytes after it are ignored until the next START.
- R2: The engine acknowledges by pulling SDA low for the whole ninth SCL pulse. It changes its SDA output only while the filtered SCL is low.
- R3: In a write, the byte after the control byte becomes the low 8 bits of the pointer. Control bits 2..1 become pointer bits 9..8. Control bit 3 has no effect with the default 10-bit address.
- R4: Each data byte is acknowledged and placed at the pointer, and the low 4 pointer bits then count up modulo 16 while the upper bits hold. A byte sent past the 16th overwrites the earlier byte at the same page slot.
- R5: A STOP that follows at least one data byte commits the buffered bytes to the array, pulses commit_o for one cycle and holds busy_o high for BUSY_CYC cycles.
- R6: A repeated START after the word address ends the write with no commit but keeps the new pointer value. A START after data bytes discards them.
- R7: In a read, the engine shifts out the byte at the pointer MSB first and advances the pointer. A master ACK brings the next byte. On a master NACK the engine releases SDA and waits for START or STOP.
- R8: A current-address read returns the location one past the last byte read or written.
- R9: While busy_o is high, the engine gives no ACK to any byte, control bytes included.
- R10: The read pointer wraps from the top address 0x3FF to 0x000.
- R11: A START or STOP at any bit position aborts the byte in progress and releases SDA. STOP returns the engine to idle.
- R12: A pulse on SCL or SDA shorter than three system clocks after synchronization has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high the pad pulls SDA low; when low the pad releases it |
| busy_o | output | 1 | High while a committed page write is in its busy period |
| commit_o | output | 1 | One-cycle pulse when buffered bytes are written to the array |

## Verification
Most faults in this engine show up on the bus within one byte. A pointer that moves wrongly returns the wrong value on the very next read byte. A bad page-wrap count puts a byte in the wrong slot, which a read of that page exposes. A miscounted bit shifts every later bit and removes the ACK on the ninth pulse. A wrong busy state shows up on the first poll after a stop, as an ACK that should have been withheld or one that never comes. An abort that is not handled shows up either as a commit_o pulse where none is expected or as a read that starts from the wrong address.

// File: rtl/twe_pkg.sv
package twe_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK,
      PH_TX,
      PH_MACK
   } phase_t;

   typedef enum logic [1:0] {
      BY_CTRL,
      BY_ADDR,
      BY_DATA
   } byte_kind_t;
endpackage

// File: rtl/twe_deglitch.sv
module twe_deglitch #(
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], din};
   end

   generate
      if (FILT_LEN < 2) begin : g_bypass
         assign dout = sync_q[1];
      end else begin : g_filter
         logic [FILT_LEN-1:0] hist_q;
         logic                out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '1;
               out_q  <= 1'b1;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
               if (&hist_q)       out_q <= 1'b1;
               else if (~|hist_q) out_q <= 1'b0;
            end
         end
         assign dout = out_q;
      end
   endgenerate
endmodule

// File: rtl/twe_bus_events.sv
module twe_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic start_ev,
   output logic stop_ev,
   output logic rise_ev,
   output logic fall_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign start_ev = scl & scl_q & sda_q & ~sda;
   assign stop_ev  = scl & scl_q & ~sda_q & sda;
   assign rise_ev  = scl & ~scl_q;
   assign fall_ev  = ~scl & scl_q;
endmodule

// File: rtl/twe_page_store.sv
module twe_page_store #(
   parameter int ADDR_W     = 10,
   parameter int PAGE_BYTES = 16,
   parameter int BUSY_CYC   = 1000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
   input  logic [7:0]                   wr_data,
   input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
   input  logic                         clear,
   input  logic                         commit_try,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [7:0]                   rd_data,
   output logic                         busy,
   output logic                         commit_o
);
   localparam int PG_W  = $clog2(PAGE_BYTES);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0]            mem_q [DEPTH];
   logic [7:0]            buf_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid_q;
   logic                  do_commit;

   assign do_commit = commit_try & (|valid_q);
   assign rd_data   = mem_q[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= '0;
         commit_o <= 1'b0;
      end else begin
         commit_o <= do_commit;
         if (do_commit || clear) valid_q <= '0;
         else if (wr_en)         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) buf_q[wr_idx] <= wr_data;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
         if (do_commit && valid_q[i])
            mem_q[{page_base, PG_W'(i)}] <= buf_q[i];
      end
   end

   generate
      if (BUSY_CYC == 0) begin : g_no_busy
         assign busy = 1'b0;
      end else begin : g_busy_timer
         localparam int BW = $clog2(BUSY_CYC + 1);
         logic [BW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          left_q <= '0;
            else if (do_commit)  left_q <= BW'(BUSY_CYC);
            else if (left_q != 0) left_q <= left_q - 1'b1;
         end
         assign busy = (left_q != 0);
      end
   endgenerate
endmodule

// File: rtl/twe_engine.sv
module twe_engine
   import twe_pkg::*;
#(
   parameter int         ADDR_W     = 10,
   parameter int         PAGE_BYTES = 16,
   parameter logic [3:0] DEV_CODE   = 4'b1010
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_ev,
   input  logic                          stop_ev,
   input  logic                          rise_ev,
   input  logic                          fall_ev,
   input  logic                          sda_f,
   input  logic                          busy,
   input  logic [7:0]                    rd_data,
   output logic [ADDR_W-1:0]             ptr,
   output logic                          wr_en,
   output logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
   output logic [7:0]                    wr_data,
   output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
   output logic                          commit_try,
   output logic                          sda_oe
);
   localparam int PG_W  = $clog2(PAGE_BYTES);
   localparam int BLK_W = ADDR_W - 8;

   phase_t          phase_q;
   byte_kind_t      kind_q;
   logic [3:0]      cnt_q;
   logic [7:0]      sh_q;
   logic [7:0]      tx_q;
   logic [BLK_W-1:0] blk_q;
   logic            rd_mode_q;
   logic            wr_mode_q;
   logic            mack_q;
   logic            byte_done;

   assign byte_done  = (phase_q == PH_RX) && fall_ev && (cnt_q == 4'd8);
   assign wr_en      = byte_done && (kind_q == BY_DATA);
   assign wr_idx     = ptr[PG_W-1:0];
   assign wr_data    = sh_q;
   assign page_base  = ptr[ADDR_W-1:PG_W];
   assign commit_try = stop_ev && wr_mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         kind_q    <= BY_CTRL;
         cnt_q     <= '0;
         sh_q      <= '0;
         tx_q      <= '0;
         blk_q     <= '0;
         rd_mode_q <= 1'b0;
         wr_mode_q <= 1'b0;
         mack_q    <= 1'b1;
         ptr       <= '0;
         sda_oe    <= 1'b0;
      end else if (start_ev) begin
         phase_q   <= PH_RX;
         kind_q    <= BY_CTRL;
         cnt_q     <= '0;
         rd_mode_q <= 1'b0;
         wr_mode_q <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (stop_ev) begin
         phase_q   <= PH_IDLE;
         cnt_q     <= '0;
         rd_mode_q <= 1'b0;
         wr_mode_q <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_RX: begin
               if (rise_ev && cnt_q != 4'd8) begin
                  sh_q  <= {sh_q[6:0], sda_f};
                  cnt_q <= cnt_q + 1'b1;
               end else if (byte_done) begin
                  cnt_q <= '0;
                  unique case (kind_q)
                     BY_CTRL: begin
                        if (sh_q[7:4] == DEV_CODE && !busy) begin
                           sda_oe    <= 1'b1;
                           phase_q   <= PH_ACK;
                           rd_mode_q <= sh_q[0];
                           wr_mode_q <= ~sh_q[0];
                           blk_q     <= sh_q[BLK_W:1];
                           kind_q    <= BY_ADDR;
                        end else begin
                           phase_q <= PH_IDLE;
                        end
                     end
                     BY_ADDR: begin
                        ptr     <= {blk_q, sh_q};
                        sda_oe  <= 1'b1;
                        phase_q <= PH_ACK;
                        kind_q  <= BY_DATA;
                     end
                     default: begin
                        ptr     <= {ptr[ADDR_W-1:PG_W], ptr[PG_W-1:0] + 1'b1};
                        sda_oe  <= 1'b1;
                        phase_q <= PH_ACK;
                     end
                  endcase
               end
            end
            PH_ACK: begin
               if (fall_ev) begin
                  cnt_q <= '0;
                  if (rd_mode_q) begin
                     tx_q    <= rd_data;
                     ptr     <= ptr + 1'b1;
                     sda_oe  <= ~rd_data[7];
                     phase_q <= PH_TX;
                  end else begin
                     sda_oe  <= 1'b0;
                     phase_q <= PH_RX;
                  end
               end
            end
            PH_TX: begin
               if (rise_ev) begin
                  cnt_q <= cnt_q + 1'b1;
               end else if (fall_ev) begin
                  if (cnt_q == 4'd8) begin
                     sda_oe  <= 1'b0;
                     phase_q <= PH_MACK;
                  end else begin
                     tx_q   <= {tx_q[6:0], 1'b0};
                     sda_oe <= ~tx_q[6];
                  end
               end
            end
            PH_MACK: begin
               if (rise_ev) begin
                  mack_q <= sda_f;
               end else if (fall_ev) begin
                  cnt_q <= '0;
                  if (!mack_q) begin
                     tx_q    <= rd_data;
                     ptr     <= ptr + 1'b1;
                     sda_oe  <= ~rd_data[7];
                     phase_q <= PH_TX;
                  end else begin
                     phase_q <= PH_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/twe_slave.sv
module twe_slave #(
   parameter int         ADDR_W     = 10,
   parameter int         PAGE_BYTES = 16,
   parameter int         BUSY_CYC   = 1000,
   parameter int         FILT_LEN   = 3,
   parameter logic [3:0] DEV_CODE   = 4'b1010
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe,
   output logic busy_o,
   output logic commit_o
);
   localparam int PG_W = $clog2(PAGE_BYTES);

   generate
      if (ADDR_W < 9 || ADDR_W > 11) begin : g_bad_addr_w
         $error("twe_slave: ADDR_W must lie in 9..11");
      end
      if (PAGE_BYTES < 2 || PAGE_BYTES > 256 || (1 << PG_W) != PAGE_BYTES) begin : g_bad_page
         $error("twe_slave: PAGE_BYTES must be a power of two in 2..256");
      end
   endgenerate

   logic scl_f, sda_f;
   logic start_ev, stop_ev, rise_ev, fall_ev;
   logic [ADDR_W-1:0]      ptr;
   logic [7:0]             rd_data, wr_data;
   logic                   wr_en, commit_try;
   logic [PG_W-1:0]        wr_idx;
   logic [ADDR_W-PG_W-1:0] page_base;

   twe_deglitch #(.FILT_LEN(FILT_LEN)) i_scl_filt (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
   twe_deglitch #(.FILT_LEN(FILT_LEN)) i_sda_filt (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

   twe_bus_events i_events (
      .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
      .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev), .fall_ev(fall_ev));

   twe_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DEV_CODE(DEV_CODE)) i_engine (
      .clk(clk), .rst_n(rst_n),
      .start_ev(start_ev), .stop_ev(stop_ev), .rise_ev(rise_ev), .fall_ev(fall_ev),
      .sda_f(sda_f), .busy(busy_o), .rd_data(rd_data), .ptr(ptr),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .page_base(page_base),
      .commit_try(commit_try), .sda_oe(sda_oe));

   twe_page_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYC(BUSY_CYC)) i_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .page_base(page_base),
      .clear(start_ev), .commit_try(commit_try), .rd_addr(ptr), .rd_data(rd_data),
      .busy(busy_o), .commit_o(commit_o));
endmodule

// File: rtl/twe_slave_chk.sv
module twe_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_f,
   input logic sda_oe,
   input logic start_ev,
   input logic stop_ev,
   input logic busy_o,
   input logic commit_o
);
   // R2: the data line driver moves only while the filtered clock is low
   a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_f);

   // R11: a bus condition always leaves the data line released
   a_r11_cond_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev || stop_ev) |=> !sda_oe);

   // R5: a commit pulse comes only from a stop condition
   a_r5_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> $past(stop_ev));

   // R5: a commit begins a busy period and never lands inside one
   a_r5_commit_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> (busy_o && !$past(busy_o)));

   // R9: nothing is driven onto the bus while busy
   a_r9_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sda_oe);
endmodule

bind twe_slave twe_slave_chk i_chk (
   .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
   .start_ev(start_ev), .stop_ev(stop_ev), .busy_o(busy_o), .commit_o(commit_o));

// File: tb/test_twe_slave.sv
module test_twe_slave;
   localparam int Q     = 10;
   localparam int DEPTH = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, busy_o, commit_o;
   logic sda_line;

   assign sda_line = sda_m & ~sda_oe;

   always #5 clk = ~clk;

   twe_slave i_twe_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .busy_o(busy_o), .commit_o(commit_o));

   int n_chk = 0;
   int n_err = 0;
   int n_commit = 0;
   logic [7:0] mdl [DEPTH];
   bit         known [DEPTH];
   int         ptr_m = 0;
   bit         done = 0;

   always @(negedge clk) if (commit_o) n_commit++;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      sda_m = 1'b0; tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      sda_m = 1'b1; tick(2*Q);
   endtask

   task automatic bit_io(input bit b, output bit s);
      sda_m = b; tick(Q);
      scl_m = 1'b1; tick(Q);
      s = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, input bit glitch, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         if (glitch && i == 3) begin
            tick(2); scl_m = 1'b1; tick(2); scl_m = 1'b0;
         end
         bit_io(v[i], s);
      end
      bit_io(1'b1, ack);
   endtask

   task automatic get_byte(input bit master_ack, output logic [7:0] v);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, s);
         v[i] = s;
      end
      bit_io(!master_ack, s);
   endtask

   function automatic logic [7:0] ctrl_byte(input int addr, input bit b3, input bit rd);
      return {4'b1010, b3, 2'(addr >> 8), rd};
   endfunction

   task automatic wait_ready();
      bit ack;
      bit ok = 0;
      for (int k = 0; k < 30 && !ok; k++) begin
         bus_start();
         put_byte(ctrl_byte(0, 1'b0, 1'b0), 1'b0, ack);
         bus_stop();
         if (!ack) ok = 1;
      end
      chk(ok, "R9", "ack returns after busy period", ok, 1);
   endtask

   // fixed < 0 picks random data bytes
   task automatic write_seq(input int addr, input int n, input bit b3,
                            input int fixed, input bit glitch, input bit poll);
      bit ack;
      int base = addr & ~15;
      int lo   = addr & 15;
      logic [7:0] d;
      bus_start();
      put_byte(ctrl_byte(addr, b3, 1'b0), 1'b0, ack);
      chk(!ack, "R1", "control byte ack", ack, 0);
      put_byte(8'(addr), 1'b0, ack);
      chk(!ack, "R3", "word address ack", ack, 0);
      for (int i = 0; i < n; i++) begin
         d = (fixed < 0) ? 8'($urandom) : 8'(fixed);
         put_byte(d, glitch, ack);
         chk(!ack, "R4", "data byte ack", ack, 0);
         mdl[base | ((lo + i) & 15)]   = d;
         known[base | ((lo + i) & 15)] = 1;
      end
      bus_stop();
      ptr_m = base | ((lo + n) & 15);
      if (poll) wait_ready();
   endtask

   task automatic read_seq(input int addr, input int n, input bit set_addr, input string req);
      bit ack;
      logic [7:0] v;
      if (set_addr) begin
         bus_start();
         put_byte(ctrl_byte(addr, 1'b0, 1'b0), 1'b0, ack);
         chk(!ack, "R6", "control ack before address", ack, 0);
         put_byte(8'(addr), 1'b0, ack);
         chk(!ack, "R6", "address ack before repeated start", ack, 0);
         ptr_m = addr;
      end
      bus_start();
      put_byte(ctrl_byte(0, 1'b0, 1'b1), 1'b0, ack);
      chk(!ack, "R7", "read control ack", ack, 0);
      for (int i = 0; i < n; i++) begin
         get_byte(i != n - 1, v);
         if (known[ptr_m]) chk(v == mdl[ptr_m], req, "read byte", v, mdl[ptr_m]);
         ptr_m = (ptr_m + 1) % DEPTH;
      end
      bus_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      bit ack;
      int c0;
      void'($urandom(32'h1C5EED));
      for (int i = 0; i < DEPTH; i++) known[i] = 0;
      tick(4);
      rst_n = 1'b1;
      tick(10);
      chk(sda_oe == 1'b0, "R11", "reset sda_oe", sda_oe, 0);
      chk(busy_o == 1'b0, "R5", "reset busy_o", busy_o, 0);
      chk(commit_o == 1'b0, "R5", "reset commit_o", commit_o, 0);

      // R1: wrong device code gets no ack and the rest is ignored
      c0 = n_commit;
      bus_start();
      put_byte(8'b1011_0000, 1'b0, ack);
      chk(ack, "R1", "wrong device code nack", ack, 1);
      put_byte(8'h10, 1'b0, ack);
      chk(ack, "R1", "byte after bad control ignored", ack, 1);
      put_byte(8'h55, 1'b0, ack);
      bus_stop();
      tick(4);
      chk(n_commit == c0, "R1", "no commit after bad control", n_commit, c0);

      // R4/R5: full page at 0x120, then byte write at 0x123 with bit 3 set (R3)
      write_seq(12'h120, 16, 1'b0, -1, 1'b0, 1'b1);
      c0 = n_commit;
      write_seq(12'h123, 1, 1'b1, 8'hA5, 1'b0, 1'b0);
      chk(n_commit == c0 + 1, "R5", "commit pulse count", n_commit, c0 + 1);
      chk(busy_o == 1'b1, "R5", "busy after stop", busy_o, 1);
      bus_start();
      put_byte(ctrl_byte(0, 1'b0, 1'b0), 1'b0, ack);
      bus_stop();
      chk(ack == 1'b1, "R9", "control nack while busy", ack, 1);
      wait_ready();
      read_seq(0, 1, 1'b0, "R8");
      read_seq(12'h120, 16, 1'b1, "R3");

      // R4: 20 bytes from slot 12 wrap inside page 0x2F0
      write_seq(12'h2FC, 20, 1'b0, -1, 1'b0, 1'b1);
      read_seq(12'h2F0, 16, 1'b1, "R4");

      // R10: read pointer wraps from top of array to zero
      write_seq(12'h3FE, 2, 1'b0, -1, 1'b0, 1'b1);
      write_seq(12'h000, 2, 1'b0, -1, 1'b0, 1'b1);
      read_seq(12'h3FE, 4, 1'b1, "R10");

      // R11/R6: START in mid data byte aborts, pointer from address kept
      c0 = n_commit;
      bus_start();
      put_byte(ctrl_byte(12'h2F5, 1'b0, 1'b0), 1'b0, ack);
      put_byte(8'hF5, 1'b0, ack);
      for (int i = 0; i < 4; i++) bit_io(1'b0, ack);
      ptr_m = 12'h2F5;
      read_seq(0, 1, 1'b0, "R11");
      tick(4);
      chk(n_commit == c0, "R6", "no commit after abort", n_commit, c0);

      // R12: short SCL pulse inside a data byte is ignored
      write_seq(12'h130, 1, 1'b0, 8'h3C, 1'b1, 1'b1);
      read_seq(12'h130, 1, 1'b1, "R12");

      // random page writes and read-backs
      for (int k = 0; k < 6; k++) begin
         int a = $urandom_range(DEPTH - 1, 0);
         int n = $urandom_range(20, 1);
         write_seq(a, n, 1'($urandom), -1, 1'b0, 1'b1);
         read_seq(0, 1, 1'b0, "R8");
         read_seq(a, (n > 16) ? 16 : n, 1'b1, "R7");
      end

      done = 1;
      summary();
   end
endmodule